// File: doc/BRIEF.md
# Serial Port Control and Status Register Block with Receive Interrupts

This block keeps the control and status state of an asynchronous/synchronous serial port. It sits between a small CPU register bus and the separate transmit and receive shift engines. The CPU enables the transmitter, the receiver and the receive interrupts through a control register. It watches and acknowledges events through a status register of sticky flags: transmit buffer empty, receive buffer full, framing error, parity error and overrun.

The shift engines report events as one-cycle strobes: a frame finished, a framing or parity error was seen, the transmit shift register was loaded, or a start bit or serial clock edge was detected. The block turns these into flag updates and two interrupt requests. It also emits one-cycle go signals that tell the engines when a transmission may begin, when reception may begin and when a finished frame may be moved into the receive buffer. A status flag is acknowledged with a two-step handshake. The CPU must first read the flag while it is 1, and then write 0 to that bit.

Top module: `serport_csr`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0x01 (only the transmit-empty flag, bit 0, set), and both interrupt requests and all go strobes are 0.
- R2: While transmit-enable (control bit 1) is 0, the transmit-empty flag (status bit 0) reads 1 and a read-then-write-0 leaves it at 1 with no transmit start.
- R3: With transmit-enable at 1, a status write of 0 to bit 0 after a read that returned it as 1 clears the flag and gives a one-cycle tx_start_o pulse in the cycle after the write. A tx_load_i strobe sets the flag again.
- R4: A write of 0 to a flag that was not read as 1 since its last clear leaves the flag set. A write of 1 to any flag has no effect.
- R5: With receive-enable (control bit 0) at 1 and the receive-full flag (status bit 1) at 0, a frame-done strobe sets receive-full and pulses rx_load_o in the next cycle.
- R6: A frame-done strobe while receive-full is 1 sets the overrun flag (status bit 4), keeps receive-full at 1 and gives no rx_load_o pulse.
- R7: With receive-enable at 1, the framing and parity error strobes set status bits 2 and 3. With receive-enable at 0, every receive strobe is ignored.
- R8: Clearing receive-enable leaves all four receive flags at their values.
- R9: irq_rxf_o equals receive-interrupt-enable (control bit 2) AND receive-full, and irq_rxe_o equals that enable AND the OR of bits 2 to 4, each one cycle after its inputs. Clearing the enable drops both.
- R10: When a set strobe and a valid CPU clear reach the same flag in the same cycle, the flag stays 1.
- R11: rx_start_o pulses the cycle after a detection strobe only when receive-enable is 1. In asynchronous mode (mode_sync_i=0) the start-bit strobe counts, and in synchronous mode (mode_sync_i=1) the clock strobe counts.
- R12: A read returns data in the next cycle: address 0 gives the 3-bit control register zero-extended, and address 1 gives the 5-bit status register zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 1 | 0 control, 1 status |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Registered read data |
| mode_sync_i | input | 1 | 1 synchronous, 0 asynchronous |
| rx_frame_done_i | input | 1 | Receive engine finished a frame |
| rx_frame_err_i | input | 1 | Framing error strobe |
| rx_parity_err_i | input | 1 | Parity error strobe |
| tx_load_i | input | 1 | Transmit shift register loaded |
| rx_start_det_i | input | 1 | Start bit detected |
| rx_clk_det_i | input | 1 | Serial clock edge detected |
| rx_start_o | output | 1 | Reception may begin |
| rx_load_o | output | 1 | Move frame into receive buffer |
| tx_start_o | output | 1 | Transmission may begin |
| irq_rxf_o | output | 1 | Receive-full interrupt request |
| irq_rxe_o | output | 1 | Receive-error interrupt request |

## Verification
A hardware set strobe and the CPU acknowledge write can reach the same flag in the same edge. The bench provokes this by first reading the status so that the read-while-set latches are armed. It then drives a status write of 0 together with a framing-error strobe on one clock. A read-back then must show the framing flag still set while receive-full, cleared by the same write, has dropped. A second read-and-clear must then remove the surviving flag.

// File: rtl/serport_pkg.sv
package serport_pkg;
  // status flag positions
  localparam int NFLAG   = 5;
  localparam int F_TXE   = 0;
  localparam int F_RXF   = 1;
  localparam int F_FER   = 2;
  localparam int F_PER   = 3;
  localparam int F_OVR   = 4;
  // control bit positions
  localparam int CT_W    = 3;
  localparam int C_RXEN  = 0;
  localparam int C_TXEN  = 1;
  localparam int C_RXIE  = 2;

  function automatic logic flag_rst_val(input int idx);
    return (idx == F_TXE);
  endfunction
endpackage

// File: rtl/serport_flag.sv
module serport_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic hold_i,
  input  logic rd_i,
  input  logic wr0_i,
  output logic flag_o,
  output logic clr_o
);
  logic armed_q;
  logic clr_req;

  assign clr_req = wr0_i & armed_q;
  assign clr_o   = clr_req & ~set_i & ~hold_i;

  always_ff @(posedge clk) begin
    if (rst)               armed_q <= 1'b0;
    else if (clr_req)      armed_q <= 1'b0;
    else if (rd_i & flag_o) armed_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                 flag_o <= RST_VAL;
    else if (set_i | hold_i) flag_o <= 1'b1;
    else if (clr_req)        flag_o <= 1'b0;
  end
endmodule

// File: rtl/serport_ctrl.sv
module serport_ctrl
  import serport_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_i,
  input  logic [CT_W-1:0] wdata_i,
  input  logic            mode_sync_i,
  input  logic            start_det_i,
  input  logic            clk_det_i,
  input  logic            tx_clr_i,
  output logic [CT_W-1:0] ctl_o,
  output logic            rx_start_o,
  output logic            tx_start_o
);
  logic det_sel;
  assign det_sel = mode_sync_i ? clk_det_i : start_det_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_o      <= '0;
      rx_start_o <= 1'b0;
      tx_start_o <= 1'b0;
    end else begin
      if (wr_i) ctl_o <= wdata_i;
      rx_start_o <= ctl_o[C_RXEN] & det_sel;
      tx_start_o <= ctl_o[C_TXEN] & tx_clr_i;
    end
  end
endmodule

// File: rtl/serport_irq.sv
module serport_irq
  import serport_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ie_i,
  input  logic [NFLAG-1:0] flag_i,
  output logic             irq_rxf_o,
  output logic             irq_rxe_o
);
  logic any_err;
  assign any_err = flag_i[F_FER] | flag_i[F_PER] | flag_i[F_OVR];

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_rxf_o <= 1'b0;
      irq_rxe_o <= 1'b0;
    end else begin
      irq_rxf_o <= ie_i & flag_i[F_RXF];
      irq_rxe_o <= ie_i & any_err;
    end
  end
endmodule

// File: rtl/serport_csr.sv
module serport_csr
  import serport_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel_i,
  input  logic          bus_wr_i,
  input  logic          bus_rd_i,
  input  logic          bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic          mode_sync_i,
  input  logic          rx_frame_done_i,
  input  logic          rx_frame_err_i,
  input  logic          rx_parity_err_i,
  input  logic          tx_load_i,
  input  logic          rx_start_det_i,
  input  logic          rx_clk_det_i,
  output logic          rx_start_o,
  output logic          rx_load_o,
  output logic          tx_start_o,
  output logic          irq_rxf_o,
  output logic          irq_rxe_o
);
  logic             ctl_wr, st_wr, st_rd, any_rd;
  logic [CT_W-1:0]  ctl_q;
  logic [NFLAG-1:0] flag_q, flag_set, flag_hold, flag_clr;
  logic             rx_on;

  assign ctl_wr = bus_sel_i & bus_wr_i & ~bus_addr_i;
  assign st_wr  = bus_sel_i & bus_wr_i & bus_addr_i;
  assign any_rd = bus_sel_i & bus_rd_i & ~bus_wr_i;
  assign st_rd  = any_rd & bus_addr_i;
  assign rx_on  = ctl_q[C_RXEN];

  always_comb begin
    flag_set         = '0;
    flag_hold        = '0;
    flag_set[F_TXE]  = tx_load_i;
    flag_hold[F_TXE] = ~ctl_q[C_TXEN];
    flag_set[F_RXF]  = rx_on & rx_frame_done_i & ~flag_q[F_RXF];
    flag_set[F_FER]  = rx_on & rx_frame_err_i;
    flag_set[F_PER]  = rx_on & rx_parity_err_i;
    flag_set[F_OVR]  = rx_on & rx_frame_done_i & flag_q[F_RXF];
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    serport_flag #(.RST_VAL(flag_rst_val(i))) u_flag (
      .clk    (clk),
      .rst    (rst),
      .set_i  (flag_set[i]),
      .hold_i (flag_hold[i]),
      .rd_i   (st_rd),
      .wr0_i  (st_wr & ~bus_wdata_i[i]),
      .flag_o (flag_q[i]),
      .clr_o  (flag_clr[i])
    );
  end

  serport_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .wr_i        (ctl_wr),
    .wdata_i     (bus_wdata_i[CT_W-1:0]),
    .mode_sync_i (mode_sync_i),
    .start_det_i (rx_start_det_i),
    .clk_det_i   (rx_clk_det_i),
    .tx_clr_i    (flag_clr[F_TXE]),
    .ctl_o       (ctl_q),
    .rx_start_o  (rx_start_o),
    .tx_start_o  (tx_start_o)
  );

  serport_irq u_irq (
    .clk       (clk),
    .rst       (rst),
    .ie_i      (ctl_q[C_RXIE]),
    .flag_i    (flag_q),
    .irq_rxf_o (irq_rxf_o),
    .irq_rxe_o (irq_rxe_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata_o <= '0;
      rx_load_o   <= 1'b0;
    end else begin
      rx_load_o <= flag_set[F_RXF];
      if (any_rd)
        bus_rdata_o <= bus_addr_i ? DW'(flag_q) : DW'(ctl_q);
    end
  end
endmodule

// File: rtl/serport_chk.sv
module serport_chk
  import serport_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [CT_W-1:0]  ctl_q,
  input logic [NFLAG-1:0] flag_q,
  input logic             bus_sel_i,
  input logic             bus_wr_i,
  input logic             bus_addr_i,
  input logic             rx_frame_done_i,
  input logic             rx_load_o,
  input logic             tx_start_o,
  input logic             irq_rxf_o,
  input logic             irq_rxe_o
);
  logic st_wr;
  assign st_wr = bus_sel_i & bus_wr_i & bus_addr_i;

  // R2
  tx_forced_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q[C_TXEN] && $past(!ctl_q[C_TXEN])) |-> flag_q[F_TXE]);

  // R3
  tx_start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_start_o |=> !tx_start_o);

  // R3
  tx_start_empty_chk: assert property (@(posedge clk) disable iff (rst)
    tx_start_o |-> !flag_q[F_TXE]);

  // R6
  overrun_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_frame_done_i && ctl_q[C_RXEN] && flag_q[F_RXF] && !st_wr)
      |=> (flag_q[F_OVR] && flag_q[F_RXF] && !rx_load_o));

  // R8
  rx_off_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q[C_RXEN] && !st_wr) |=> $stable(flag_q[NFLAG-1:F_RXF]));

  // R9
  irq_off_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl_q[C_RXIE] |=> (!irq_rxf_o && !irq_rxe_o));

  // R9
  irq_full_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[C_RXIE] && flag_q[F_RXF]) |=> irq_rxf_o);
endmodule

bind serport_csr serport_chk u_chk (
  .clk             (clk),
  .rst             (rst),
  .ctl_q           (ctl_q),
  .flag_q          (flag_q),
  .bus_sel_i       (bus_sel_i),
  .bus_wr_i        (bus_wr_i),
  .bus_addr_i      (bus_addr_i),
  .rx_frame_done_i (rx_frame_done_i),
  .rx_load_o       (rx_load_o),
  .tx_start_o      (tx_start_o),
  .irq_rxf_o       (irq_rxf_o),
  .irq_rxe_o       (irq_rxe_o)
);

// File: tb/test_serport_csr.sv
module test_serport_csr;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_sel = 0, bus_wr = 0, bus_rd = 0, bus_addr = 0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic mode_sync = 0, frame_done = 0, frame_err = 0, parity_err = 0;
  logic tx_load = 0, start_det = 0, clk_det = 0;
  logic rx_start, rx_load, tx_start, irq_rxf, irq_rxe;
  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serport_csr #(.DW(DW)) i_serport_csr (
    .clk(clk), .rst(rst), .bus_sel_i(bus_sel), .bus_wr_i(bus_wr),
    .bus_rd_i(bus_rd), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .mode_sync_i(mode_sync),
    .rx_frame_done_i(frame_done), .rx_frame_err_i(frame_err),
    .rx_parity_err_i(parity_err), .tx_load_i(tx_load),
    .rx_start_det_i(start_det), .rx_clk_det_i(clk_det),
    .rx_start_o(rx_start), .rx_load_o(rx_load), .tx_start_o(tx_start),
    .irq_rxf_o(irq_rxf), .irq_rxe_o(irq_rxe)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic bus_write(input logic a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_sel = 0; bus_rd = 0;
    d = bus_rdata;
  endtask

  // 0 frame_done, 1 frame_err, 2 parity_err, 3 tx_load, 4 start_det, 5 clk_det
  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: frame_done = 1;
      1: frame_err  = 1;
      2: parity_err = 1;
      3: tx_load    = 1;
      4: start_det  = 1;
      default: clk_det = 1;
    endcase
    @(negedge clk);
    frame_done = 0; frame_err = 0; parity_err = 0;
    tx_load = 0; start_det = 0; clk_det = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    tick();
    // R1 reset state
    check("R1 irq_rxf", irq_rxf, 0);
    check("R1 irq_rxe", irq_rxe, 0);
    check("R1 strobes", {rx_start, rx_load, tx_start}, 0);
    bus_read(0, d); check("R1 control", d, 8'h00);
    bus_read(1, d); check("R1 status", d, 8'h01);

    // R2 transmitter off: empty cannot be cleared
    bus_write(1, 8'h00);
    check("R2 tx_start", tx_start, 0);
    bus_read(1, d); check("R2 status", d, 8'h01);

    // R11 sweep control x mode x strobe kind
    for (int c = 0; c < 8; c++) begin
      for (int m = 0; m < 2; m++) begin
        for (int k = 0; k < 2; k++) begin
          bus_write(0, DW'(c));
          mode_sync = m[0];
          pulse(k == 0 ? 4 : 5);
          check("R11 rx_start", rx_start,
                int'(c[0] & (m[0] ? (k == 1) : (k == 0))));
        end
      end
    end
    bus_write(0, 8'h00);
    mode_sync = 0;

    // R3 clear empty with transmitter on
    bus_write(0, 8'h02);
    bus_read(1, d); check("R3 status before", d, 8'h01);
    bus_write(1, 8'h00);
    check("R3 tx_start pulse", tx_start, 1);
    bus_read(1, d); check("R3 status cleared", d, 8'h00);
    check("R3 tx_start ends", tx_start, 0);
    pulse(3);
    // R4 write 0 without prior read while set
    bus_write(1, 8'h00);
    check("R4 no tx_start", tx_start, 0);
    bus_read(1, d); check("R4 unread not cleared", d, 8'h01);
    bus_write(1, 8'h01);
    bus_read(1, d); check("R4 write one no effect", d, 8'h01);
    bus_write(1, 8'h00);
    check("R3 tx_start after armed", tx_start, 1);
    bus_read(1, d); check("R3 cleared after arm", d, 8'h00);
    bus_write(0, 8'h00);
    tick();
    bus_read(1, d); check("R2 forced after disable", d, 8'h01);

    // R5 receive full
    bus_write(0, 8'h05);
    pulse(0);
    check("R5 rx_load", rx_load, 1);
    tick();
    check("R9 irq_rxf on", irq_rxf, 1);
    check("R9 irq_rxe off", irq_rxe, 0);
    bus_read(1, d); check("R5 status", d, 8'h03);

    // R6 overrun
    pulse(0);
    check("R6 no rx_load", rx_load, 0);
    tick();
    bus_read(1, d); check("R6 status", d, 8'h13);
    check("R9 irq_rxe on", irq_rxe, 1);

    // R9 disable interrupts
    bus_write(0, 8'h01);
    tick();
    check("R9 irq off", {irq_rxf, irq_rxe}, 0);

    // R8 and R7 receiver off
    bus_write(0, 8'h00);
    bus_read(1, d); check("R8 flags kept", d, 8'h13);
    pulse(1); pulse(2); pulse(0);
    check("R7 no rx_load when off", rx_load, 0);
    bus_read(1, d); check("R7 ignored when off", d, 8'h13);

    // R7 error strobes
    bus_write(0, 8'h01);
    pulse(1);
    pulse(2);
    bus_read(1, d); check("R7 errors set", d, 8'h1F);
    bus_write(1, 8'h00);
    bus_read(1, d); check("R4 armed clear", d, 8'h01);

    // R10 set beats clear
    pulse(0);
    bus_read(1, d); check("R10 setup full", d, 8'h03);
    pulse(1);
    bus_read(1, d); check("R10 setup err", d, 8'h07);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 1; bus_wdata = 8'h00; frame_err = 1;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; frame_err = 0;
    bus_read(1, d); check("R10 set wins", d, 8'h05);
    bus_write(1, 8'h00);
    bus_read(1, d); check("R10 later clear", d, 8'h01);

    // R12 control width
    bus_write(0, 8'hFF);
    bus_read(0, d); check("R12 control read", d, 8'h07);
    bus_write(0, 8'h00);
    tick();
    finish_run();
  end
endmodule